// File: doc/BRIEF.md
# Multi-Sample Trigger Sequencer with Loss Vetoes

This block converts a level-1 accept strobe into the serial trigger stream of a front-end readout chip. For each L1 it forwards, it sends two trigger symbols back to back on a single-bit line. Each symbol is the bit pattern 1,0,0, sent most significant bit first at one bit per clock. Each symbol asks the chip for three samples along the shaped pulse, so one forwarded L1 asks for six.

Two rules can stop an L1 from being forwarded. The first is spacing: an L1 is refused while the previous symbol pair is still being sent. The second is capacity: the block keeps a shadow count of the samples waiting in the chip's pending-readout buffer, and it refuses any L1 whose six samples would push that count past 32. The shadow count goes down by one for every readout-frame-done strobe. Each kind of refusal has its own saturating 16-bit counter, and a synchronous clear input zeroes both counters.

Top module: `trig_seq_top`

## Requirements
- R1: An accepted L1 (sampled at clock edge t) drives `trig_out` with the sequence 1,0,0,1,0,0 during the six cycles after edge t, one bit per cycle. The line is 0 at all other times.
- R2: An L1 sampled fewer than 6 edges after the last accepted L1 is refused, and `spacing_losses` increments. An L1 sampled exactly 6 edges after it is accepted. `l1_accept` is high in the cycle of an accepted L1 and low otherwise.
- R3: Each accepted L1 adds 6 to `occ_level`.
- R4: An L1 that passes the spacing rule is refused when `occ_level` + 6 > 32, and `overflow_losses` increments. At `occ_level` = 26 the L1 is accepted and the level reaches 32. `occ_level` never exceeds 32.
- R5: Each cycle with `frame_done` high lowers `occ_level` by one. A `frame_done` at level 0 with no accept in the same cycle is ignored, and the level stays 0.
- R6: An accept and a `frame_done` in the same cycle change `occ_level` by +5.
- R7: An L1 that breaks both rules counts only as a spacing loss. `overflow_losses` does not change.
- R8: Both loss counters stop at 65535 and stay there while losses continue.
- R9: `loss_clr` zeroes both loss counters on the next edge. It takes priority over a loss in the same cycle and leaves `occ_level` unchanged.
- R10: After reset, `trig_out` is 0, `occ_level` is 0 and both counters are 0. An L1 on the first cycle after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_in | input | 1 | Level-1 accept strobe, one cycle per request |
| frame_done | input | 1 | One readout frame finished; one sample leaves the buffer |
| loss_clr | input | 1 | Synchronous clear of both loss counters |
| trig_out | output | 1 | Serial trigger line to the front-end chip |
| l1_accept | output | 1 | High in the cycle an L1 is forwarded |
| occ_level | output | 6 | Shadow occupancy of the pending-sample buffer |
| spacing_losses | output | 16 | L1s refused by the spacing rule |
| overflow_losses | output | 16 | L1s refused by the capacity rule |

## Verification
The two functions that can collide in one cycle are the increment of the occupancy count by an accepted L1 and its decrement by `frame_done`. The bench makes them collide in two ways. It pulses both inputs together at a level of 0, where the decrement alone would be ignored. It also holds `frame_done` and `l1_in` high together for a long run, so every accept meets a decrement. A behavioural model in the bench computes the expected level as the sum of both effects, and the outputs are compared against that model on every clock. Directed checks also look for the exact values 5 and 10.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    // Outcome of evaluating one incoming L1 request
    typedef enum logic [1:0] {
        VERDICT_IDLE     = 2'd0,
        VERDICT_ACCEPT   = 2'd1,
        VERDICT_TOO_SOON = 2'd2,
        VERDICT_FULL     = 2'd3
    } verdict_e;

    // Decision bundle carried from the arbitration logic to the datapath
    typedef struct packed {
        verdict_e verdict;
        logic     start_seq;
        logic     add_samples;
    } decision_t;

    // Indices of the loss counters
    localparam int LOSS_SPACING  = 0;
    localparam int LOSS_OVERFLOW = 1;
    localparam int LOSS_KINDS    = 2;

    // A symbol starts with a 1 and continues with zeros; pos counts sent bits
    function automatic logic seq_bit(input int pos, input int sym_bits);
        return (pos % sym_bits) == 0;
    endfunction

endpackage

// File: rtl/spacing_guard.sv
module spacing_guard #(
    parameter int MIN_GAP = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic blocked
);
    localparam int HW = $clog2(MIN_GAP + 1);
    localparam logic [HW-1:0] RELOAD = HW'(MIN_GAP - 1);

    logic [HW-1:0] hold_q;

    // Counts down the edges still inside the holdoff window after an accept
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= RELOAD;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
        end
    end

    assign blocked = (hold_q != '0);

endmodule

// File: rtl/occ_tracker.sv
module occ_tracker #(
    parameter int BUF_DEPTH = 32,
    parameter int STEP      = 6,
    parameter int OCC_W     = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic             would_overflow,
    output logic [OCC_W-1:0] level
);
    localparam int XW = OCC_W + 1;
    localparam logic [XW-1:0] STEP_X  = XW'(STEP);
    localparam logic [XW-1:0] LIMIT_X = XW'(BUF_DEPTH);

    logic [OCC_W-1:0] occ_q;
    logic [XW-1:0]    grown;
    logic [XW-1:0]    shrunk;

    // Apply the increment first, then the decrement, so both land together
    always_comb begin
        grown  = {1'b0, occ_q} + (inc ? STEP_X : '0);
        shrunk = (dec && (grown != '0)) ? grown - XW'(1) : grown;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= OCC_W'(shrunk);
        end
    end

    assign would_overflow = ({1'b0, occ_q} + STEP_X) > LIMIT_X;
    assign level          = occ_q;

endmodule

// File: rtl/symbol_shifter.sv
module symbol_shifter #(
    parameter int SYM_BITS  = 3,
    parameter int SYM_COUNT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic line
);
    import trig_seq_pkg::*;

    localparam int SEQ_BITS = SYM_BITS * SYM_COUNT;

    logic [SEQ_BITS-1:0] pattern;
    logic [SEQ_BITS-1:0] sreg_q;

    // Sent order runs from the MSB down; each symbol begins with a 1
    for (genvar g = 0; g < SEQ_BITS; g++) begin : g_pat
        assign pattern[SEQ_BITS-1-g] = seq_bit(g, SYM_BITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
        end else if (start) begin
            sreg_q <= pattern;
        end else begin
            sreg_q <= {sreg_q[SEQ_BITS-2:0], 1'b0};
        end
    end

    assign line = sreg_q[SEQ_BITS-1];

endmodule

// File: rtl/loss_counter.sv
module loss_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hit,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    // Clear wins over a hit; the count sticks at all ones
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (hit && (cnt_q != '1)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top #(
    parameter int SYM_BITS        = 3,
    parameter int SYM_COUNT       = 2,
    parameter int SAMPLES_PER_SYM = 3,
    parameter int BUF_DEPTH       = 32,
    parameter int CNT_W           = 16,
    parameter int OCC_W           = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             l1_in,
    input  logic             frame_done,
    input  logic             loss_clr,
    output logic             trig_out,
    output logic             l1_accept,
    output logic [OCC_W-1:0] occ_level,
    output logic [CNT_W-1:0] spacing_losses,
    output logic [CNT_W-1:0] overflow_losses
);
    import trig_seq_pkg::*;

    localparam int SEQ_BITS       = SYM_BITS * SYM_COUNT;
    localparam int MIN_GAP        = SEQ_BITS;
    localparam int SAMPLES_PER_L1 = SAMPLES_PER_SYM * SYM_COUNT;

    logic      too_soon;
    logic      too_full;
    decision_t dec;

    // Spacing is judged before capacity
    always_comb begin
        dec.verdict = VERDICT_IDLE;
        if (l1_in) begin
            if (too_soon) begin
                dec.verdict = VERDICT_TOO_SOON;
            end else if (too_full) begin
                dec.verdict = VERDICT_FULL;
            end else begin
                dec.verdict = VERDICT_ACCEPT;
            end
        end
        dec.start_seq   = (dec.verdict == VERDICT_ACCEPT);
        dec.add_samples = (dec.verdict == VERDICT_ACCEPT);
    end

    spacing_guard #(.MIN_GAP(MIN_GAP)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .load    (dec.start_seq),
        .blocked (too_soon)
    );

    occ_tracker #(
        .BUF_DEPTH (BUF_DEPTH),
        .STEP      (SAMPLES_PER_L1),
        .OCC_W     (OCC_W)
    ) u_occ (
        .clk            (clk),
        .rst            (rst),
        .inc            (dec.add_samples),
        .dec            (frame_done),
        .would_overflow (too_full),
        .level          (occ_level)
    );

    symbol_shifter #(
        .SYM_BITS  (SYM_BITS),
        .SYM_COUNT (SYM_COUNT)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (dec.start_seq),
        .line  (trig_out)
    );

    logic [LOSS_KINDS-1:0] loss_hit;
    logic [CNT_W-1:0]      loss_cnt [LOSS_KINDS];

    assign loss_hit[LOSS_SPACING]  = (dec.verdict == VERDICT_TOO_SOON);
    assign loss_hit[LOSS_OVERFLOW] = (dec.verdict == VERDICT_FULL);

    for (genvar k = 0; k < LOSS_KINDS; k++) begin : g_loss
        loss_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (loss_clr),
            .hit   (loss_hit[k]),
            .count (loss_cnt[k])
        );
    end

    assign spacing_losses  = loss_cnt[LOSS_SPACING];
    assign overflow_losses = loss_cnt[LOSS_OVERFLOW];
    assign l1_accept       = dec.start_seq;

endmodule

// File: rtl/trig_seq_checker.sv
module trig_seq_checker #(
    parameter int BUF_DEPTH = 32,
    parameter int STEP      = 6,
    parameter int MIN_GAP   = 6,
    parameter int SEQ_BITS  = 6,
    parameter int OCC_W     = 6,
    parameter int CNT_W     = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             l1_in,
    input logic             frame_done,
    input logic             loss_clr,
    input logic             trig_out,
    input logic             l1_accept,
    input logic [OCC_W-1:0] occ_level,
    input logic [CNT_W-1:0] spacing_losses,
    input logic [CNT_W-1:0] overflow_losses
);
    localparam int SW = $clog2(MIN_GAP + SEQ_BITS + 2) + 1;

    // Edges since the last accept, saturating; open after reset
    logic [SW-1:0] since_acc;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_acc <= '1;
        end else if (l1_accept) begin
            since_acc <= SW'(1);
        end else if (since_acc != '1) begin
            since_acc <= since_acc + SW'(1);
        end
    end

    AST_TRIG_LEAD: assert property (@(posedge clk) disable iff (rst)
        l1_accept |=> trig_out); // R1
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (int'(since_acc) > SEQ_BITS) |-> !trig_out); // R1
    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        l1_accept |-> (int'(since_acc) >= MIN_GAP)); // R2
    AST_OCC_RISE: assert property (@(posedge clk) disable iff (rst)
        (l1_accept && !frame_done) |=> (int'(occ_level) == int'($past(occ_level)) + STEP)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(occ_level) <= BUF_DEPTH); // R4
    AST_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (occ_level == '0 && !l1_accept && frame_done) |=> (occ_level == '0)); // R5
    AST_BOTH_EDGES: assert property (@(posedge clk) disable iff (rst)
        (l1_accept && frame_done) |=> (int'(occ_level) == int'($past(occ_level)) + STEP - 1)); // R6
    AST_SPACING_FIRST: assert property (@(posedge clk) disable iff (rst)
        (l1_in && int'(since_acc) < MIN_GAP && !loss_clr) |=> $stable(overflow_losses)); // R7
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (spacing_losses == '1 && !loss_clr) |=> (spacing_losses == '1)); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        loss_clr |=> (spacing_losses == '0 && overflow_losses == '0)); // R9

endmodule

bind trig_seq_top trig_seq_checker #(
    .BUF_DEPTH (BUF_DEPTH),
    .STEP      (SAMPLES_PER_L1),
    .MIN_GAP   (MIN_GAP),
    .SEQ_BITS  (SEQ_BITS),
    .OCC_W     (OCC_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .l1_in           (l1_in),
    .frame_done      (frame_done),
    .loss_clr        (loss_clr),
    .trig_out        (trig_out),
    .l1_accept       (l1_accept),
    .occ_level       (occ_level),
    .spacing_losses  (spacing_losses),
    .overflow_losses (overflow_losses)
);

// File: tb/tb_trig_seq_top.sv
module tb_trig_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l1_in = 1'b0;
    logic        frame_done = 1'b0;
    logic        loss_clr = 1'b0;
    logic        trig_out;
    logic        l1_accept;
    logic [5:0]  occ_level;
    logic [15:0] spacing_losses;
    logic [15:0] overflow_losses;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trig_seq_top dut (
        .clk             (clk),
        .rst             (rst),
        .l1_in           (l1_in),
        .frame_done      (frame_done),
        .loss_clr        (loss_clr),
        .trig_out        (trig_out),
        .l1_accept       (l1_accept),
        .occ_level       (occ_level),
        .spacing_losses  (spacing_losses),
        .overflow_losses (overflow_losses)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_since = 1000;
    int m_occ   = 0;
    int m_sp    = 0;
    int m_ov    = 0;
    bit m_line[$];
    bit m_acc   = 0;
    bit m_go    = 0;
    bit m_wants_acc;

    always @(posedge clk) begin
        if (rst) begin
            m_since = 1000; m_occ = 0; m_sp = 0; m_ov = 0;
            m_line.delete(); m_go = 1;
        end else begin
            m_wants_acc = 0;
            if (l1_in) begin
                if (m_since < 6) begin
                    if (!loss_clr && m_sp < 65535) m_sp++;
                end else if (m_occ + 6 > 32) begin
                    if (!loss_clr && m_ov < 65535) m_ov++;
                end else begin
                    m_wants_acc = 1;
                end
            end
            if (loss_clr) begin m_sp = 0; m_ov = 0; end
            if (m_wants_acc) m_occ += 6;
            if (frame_done && m_occ > 0) m_occ--;
            if (m_wants_acc) begin
                m_line = '{1, 0, 0, 1, 0, 0};
                m_since = 1;
            end else begin
                if (m_line.size() > 0) void'(m_line.pop_front());
                if (m_since < 1000) m_since++;
            end
        end
    end

    // Accept flag is combinational on the current inputs
    always_comb m_acc = !rst && l1_in && (m_since >= 6) && (m_occ + 6 <= 32);

    always @(negedge clk) begin
        if (m_go) begin
            check("R1 trig_out", int'(trig_out), (m_line.size() > 0) ? int'(m_line[0]) : 0);
            check("R2 l1_accept", int'(l1_accept), int'(m_acc));
            check("R3 occ_level", int'(occ_level), m_occ);
            check("R2 spacing_losses", int'(spacing_losses), m_sp);
            check("R4 overflow_losses", int'(overflow_losses), m_ov);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_l1();
        l1_in = 1'b1; tick(); l1_in = 1'b0;
    endtask

    int sp_before;
    int ov_before;

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        idle(3);
        @(negedge clk);
        // R10: reset state
        check("R10 trig_out at reset", int'(trig_out), 0);
        check("R10 occ_level at reset", int'(occ_level), 0);
        check("R10 spacing_losses at reset", int'(spacing_losses), 0);
        check("R10 overflow_losses at reset", int'(overflow_losses), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        // R10: L1 right after reset is accepted; R1 sequence follows
        l1_in = 1'b1;
        @(negedge clk);
        check("R10 first L1 accepted", int'(l1_accept), 1);
        @(posedge clk); #1; l1_in = 1'b0;
        idle(2);
        // R2: L1 three edges after accept is refused
        sp_before = int'(spacing_losses);
        pulse_l1();
        @(negedge clk);
        check("R2 early L1 counted", int'(spacing_losses), sp_before + 1);
        // R2: exactly six edges after accept is accepted (edges t+3 used, now at t+4)
        @(posedge clk); #1;
        idle(1);
        l1_in = 1'b1;
        @(negedge clk);
        check("R2 L1 at gap six accepted", int'(l1_accept), 1);
        @(posedge clk); #1; l1_in = 1'b0;

        // R5: drain to zero and keep draining
        frame_done = 1'b1; idle(40); frame_done = 1'b0;
        @(negedge clk);
        check("R5 level floors at zero", int'(occ_level), 0);
        @(posedge clk); #1;
        idle(6);

        // R3: five accepts reach 30
        for (int i = 0; i < 5; i++) begin
            pulse_l1(); idle(5);
        end
        @(negedge clk);
        check("R3 five accepts give 30", int'(occ_level), 30);
        // R4: next L1 overflows
        @(posedge clk); #1;
        ov_before = int'(overflow_losses);
        pulse_l1();
        @(negedge clk);
        check("R4 overflow counted", int'(overflow_losses), ov_before + 1);
        check("R4 level held at 30", int'(occ_level), 30);
        @(posedge clk); #1;
        frame_done = 1'b1; idle(4); frame_done = 1'b0;
        idle(2);
        pulse_l1();
        @(negedge clk);
        check("R4 level 26 accepted to 32", int'(occ_level), 32);
        @(posedge clk); #1;

        // R7: full and too soon -> only spacing loss
        sp_before = int'(spacing_losses);
        ov_before = int'(overflow_losses);
        pulse_l1();
        @(negedge clk);
        check("R7 spacing counted", int'(spacing_losses), sp_before + 1);
        check("R7 overflow untouched", int'(overflow_losses), ov_before);
        @(posedge clk); #1;
        idle(6);

        // R9: clear together with an overflow loss
        l1_in = 1'b1; loss_clr = 1'b1; tick(); l1_in = 1'b0; loss_clr = 1'b0;
        @(negedge clk);
        check("R9 spacing cleared", int'(spacing_losses), 0);
        check("R9 overflow cleared", int'(overflow_losses), 0);
        check("R9 level unchanged", int'(occ_level), 32);
        @(posedge clk); #1;

        // R6: simultaneous accept and frame_done at zero and at five
        frame_done = 1'b1; idle(40); frame_done = 1'b0;
        idle(6);
        l1_in = 1'b1; frame_done = 1'b1; tick(); l1_in = 1'b0; frame_done = 1'b0;
        @(negedge clk);
        check("R6 both at zero give 5", int'(occ_level), 5);
        @(posedge clk); #1;
        idle(6);
        l1_in = 1'b1; frame_done = 1'b1; tick(); l1_in = 1'b0; frame_done = 1'b0;
        @(negedge clk);
        check("R6 both at five give 10", int'(occ_level), 10);
        @(posedge clk); #1;
        idle(6);

        // R8: overflow counter saturates with L1 held high and no drain
        l1_in = 1'b1; idle(65600); l1_in = 1'b0;
        @(negedge clk);
        check("R8 overflow saturated", int'(overflow_losses), 65535);
        @(posedge clk); #1;
        loss_clr = 1'b1; tick(); loss_clr = 1'b0;
        // R8: spacing counter saturates; drain keeps room for accepts
        l1_in = 1'b1; frame_done = 1'b1; idle(79000); l1_in = 1'b0; frame_done = 1'b0;
        @(negedge clk);
        check("R8 spacing saturated", int'(spacing_losses), 65535);
        @(posedge clk); #1;
        idle(8);
        @(negedge clk);
        check("R1 line idle low", int'(trig_out), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule